// File: doc/BRIEF.md
# Grouped MSI and INTx Interrupt Concentrator

This block gathers 32 message-signalled interrupt vectors and four level-sensitive legacy INTx inputs and presents them to a host interrupt controller as eight MSI host lines and four INTx host lines. A message-signalled interrupt arrives as a bus write of the vector number to a doorbell register. The vectors are spread across the eight MSI groups by their low three bits, so each group collects every eighth vector. Each group has a sticky pending register, an enable mask, and one host line.

Software reads a group's pending bits, clears them by writing ones, and changes its enable mask with separate set and clear registers. A host line rises when its group holds an enabled pending bit, and it stays high until software writes the group's code to the end-of-interrupt register. If an enabled pending bit is still present after that write, the line rises again. The INTx lines use the same arming scheme, but their pending bit follows the sampled input level. All register access goes through a simple single-cycle 32-bit bus whose read data appears one cycle after the request.

Top module: `irq_block`

## Requirements
- R1: After reset, all pending bits, all enable bits, all host lines and the read data output are 0.
- R2: A doorbell write (address 0x054) of value v < 32 sets pending bit v>>3 of MSI group v mod 8. Group g's pending register is at 0x104 + 16g. A doorbell value of 32 or more changes nothing.
- R3: Writing to an MSI pending register clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R4: A write to 0x108 + 16g ORs the data into group g's enable mask. A write to 0x10C + 16g removes the bits written as 1. Both addresses read back the current mask.
- R5: While MSI line g is low and group g has a pending bit that is also enabled, line g goes high on the next clock edge.
- R6: MSI line g stays high, even after its pending bits are cleared, until an end-of-interrupt write (address 0x050) of value g+4. That write drops the line on the same edge. If an enabled pending bit remains, the line rises again one edge later.
- R7: A pending bit whose enable bit is 0 does not raise the host line.
- R8: The pending bit of INTx line i (bit 0 of 0x184 + 16i) follows input intx_in[i] one edge later. Writes to it are ignored. Its enable is bit 0 of 0x188 + 16i (set) and 0x18C + 16i (clear). INTx host line i arms and fires like an MSI line and is released by an end-of-interrupt value of i.
- R9: An end-of-interrupt value that belongs to another line, or a value of 12 or more, leaves a high host line unchanged.
- R10: Read data appears on the cycle after the read request. Addresses that are unmapped or misaligned read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| intx_in | input | 4 | Legacy INTx input levels |
| msi_line | output | 8 | MSI host lines, one per group |
| intx_line | output | 4 | INTx host lines |

## Verification
A write lands in the pending, enable or end-of-interrupt state on the edge that captures it. A host line responds one edge after a pending or enable change, but an end-of-interrupt write drops it on the capturing edge. Read data is due on the edge after the request, and the INTx pending bit lags its input by one edge. The bench drives and samples on falling edges. After each stimulus it waits the exact number of falling edges, 0 or 1 after the write completes, before it samples a line. Read results are queued when the read is issued and compared by a monitor one edge later.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int ADDR_W       = 12;
    localparam int DATA_W       = 32;
    localparam int STRIDE_LOG2  = 4;
    localparam logic [ADDR_W-1:0] EOI_ADDR      = 12'h050;
    localparam logic [ADDR_W-1:0] DOORBELL_ADDR = 12'h054;
    localparam logic [ADDR_W-1:0] MSI_BASE      = 12'h100;
    localparam logic [ADDR_W-1:0] INTX_BASE     = 12'h180;
    localparam int EOI_MSI_OFS  = 4;

    typedef enum logic [1:0] {
        SUB_NONE   = 2'd0,
        SUB_STATUS = 2'd1,
        SUB_EN_SET = 2'd2,
        SUB_EN_CLR = 2'd3
    } sub_e;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
    parameter int WIDTH  = 4,
    parameter bit STICKY = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    input  logic [WIDTH-1:0] en_set_i,
    input  logic [WIDTH-1:0] en_clr_i,
    input  logic             eoi_i,
    output logic [WIDTH-1:0] status_o,
    output logic [WIDTH-1:0] enable_o,
    output logic             line_o
);
    typedef struct packed {
        logic [WIDTH-1:0] status;
        logic [WIDTH-1:0] enable;
        logic             line;
    } grp_st_t;

    grp_st_t          s_d, s_q;
    logic [WIDTH-1:0] status_nx;

    generate
        if (STICKY) begin : g_sticky
            assign status_nx = (s_q.status & ~clr_i) | set_i;
        end else begin : g_level
            assign status_nx = set_i & ~clr_i;
        end
    endgenerate

    always_comb begin
        s_d        = s_q;
        s_d.status = status_nx;
        s_d.enable = (s_q.enable | en_set_i) & ~en_clr_i;
        if (eoi_i) begin
            s_d.line = 1'b0;
        end else if (|(s_q.status & s_q.enable)) begin
            s_d.line = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o = s_q.status;
    assign enable_o = s_q.enable;
    assign line_o   = s_q.line;
endmodule

// File: rtl/irq_block.sv
module irq_block #(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_BITS = 4,
    parameter int NUM_INTX   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic [irq_pkg::ADDR_W-1:0]   bus_addr,
    input  logic [irq_pkg::DATA_W-1:0]   bus_wdata,
    output logic [irq_pkg::DATA_W-1:0]   bus_rdata,
    input  logic [NUM_INTX-1:0]          intx_in,
    output logic [NUM_GROUPS-1:0]        msi_line,
    output logic [NUM_INTX-1:0]          intx_line
);
    import irq_pkg::*;

    localparam int VECTORS = NUM_GROUPS * GROUP_BITS;
    localparam int GRP_W   = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int BIT_W   = (GROUP_BITS > 1) ? $clog2(GROUP_BITS) : 1;
    localparam int INTX_W  = (NUM_INTX > 1) ? $clog2(NUM_INTX) : 1;
    localparam logic [ADDR_W-1:0] MSI_END  = MSI_BASE + ADDR_W'(NUM_GROUPS << STRIDE_LOG2);
    localparam logic [ADDR_W-1:0] INTX_END = INTX_BASE + ADDR_W'(NUM_INTX << STRIDE_LOG2);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [NUM_GROUPS-1:0][GROUP_BITS-1:0] dbell_set, msi_w1c, msi_ens, msi_enc;
    logic [NUM_GROUPS-1:0][GROUP_BITS-1:0] msi_stat, msi_en;
    logic [NUM_GROUPS-1:0]                 msi_eoi;
    logic [NUM_INTX-1:0]                   intx_ens, intx_enc, intx_eoi, intx_stat, intx_en;
    logic [NUM_GROUPS*GROUP_BITS-1:0]      msi_stat_flat, msi_en_flat;

    logic              wr, msi_hit, intx_hit;
    logic [ADDR_W-1:0] msi_off, intx_off;
    logic [GRP_W-1:0]  msi_idx;
    logic [INTX_W-1:0] intx_idx;
    sub_e              sub;

    always_comb begin
        wr       = bus_valid & bus_write;
        msi_off  = bus_addr - MSI_BASE;
        intx_off = bus_addr - INTX_BASE;
        msi_idx  = msi_off[STRIDE_LOG2 +: GRP_W];
        intx_idx = intx_off[STRIDE_LOG2 +: INTX_W];
        sub      = sub_e'(bus_addr[3:2]);
        msi_hit  = (bus_addr >= MSI_BASE) && (bus_addr < MSI_END) && (bus_addr[1:0] == 2'b00);
        intx_hit = (bus_addr >= INTX_BASE) && (bus_addr < INTX_END) && (bus_addr[1:0] == 2'b00);

        dbell_set = '0;
        msi_w1c   = '0;
        msi_ens   = '0;
        msi_enc   = '0;
        msi_eoi   = '0;
        intx_ens  = '0;
        intx_enc  = '0;
        intx_eoi  = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (wr && bus_addr == DOORBELL_ADDR && bus_wdata < DATA_W'(VECTORS)
                && bus_wdata[GRP_W-1:0] == GRP_W'(g))
                dbell_set[g][bus_wdata[GRP_W +: BIT_W]] = 1'b1;
            if (wr && msi_hit && msi_idx == GRP_W'(g)) begin
                if (sub == SUB_STATUS) msi_w1c[g] = bus_wdata[GROUP_BITS-1:0];
                if (sub == SUB_EN_SET) msi_ens[g] = bus_wdata[GROUP_BITS-1:0];
                if (sub == SUB_EN_CLR) msi_enc[g] = bus_wdata[GROUP_BITS-1:0];
            end
            msi_eoi[g] = wr && bus_addr == EOI_ADDR && bus_wdata == DATA_W'(g + EOI_MSI_OFS);
        end
        for (int i = 0; i < NUM_INTX; i++) begin
            if (wr && intx_hit && intx_idx == INTX_W'(i)) begin
                intx_ens[i] = (sub == SUB_EN_SET) && bus_wdata[0];
                intx_enc[i] = (sub == SUB_EN_CLR) && bus_wdata[0];
            end
            intx_eoi[i] = wr && bus_addr == EOI_ADDR && bus_wdata == DATA_W'(i);
        end
    end

    always_comb begin
        s_d = s_q;
        if (bus_valid && !bus_write) begin
            s_d.rdata = '0;
            if (msi_hit) begin
                case (sub)
                    SUB_STATUS:             s_d.rdata = DATA_W'(msi_stat[msi_idx]);
                    SUB_EN_SET, SUB_EN_CLR: s_d.rdata = DATA_W'(msi_en[msi_idx]);
                    default:                s_d.rdata = '0;
                endcase
            end else if (intx_hit) begin
                case (sub)
                    SUB_STATUS:             s_d.rdata = DATA_W'(intx_stat[intx_idx]);
                    SUB_EN_SET, SUB_EN_CLR: s_d.rdata = DATA_W'(intx_en[intx_idx]);
                    default:                s_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_msi
            irq_group #(.WIDTH(GROUP_BITS), .STICKY(1'b1)) u_grp (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_i    (dbell_set[g]),
                .clr_i    (msi_w1c[g]),
                .en_set_i (msi_ens[g]),
                .en_clr_i (msi_enc[g]),
                .eoi_i    (msi_eoi[g]),
                .status_o (msi_stat[g]),
                .enable_o (msi_en[g]),
                .line_o   (msi_line[g])
            );
        end
        for (genvar i = 0; i < NUM_INTX; i++) begin : g_intx
            irq_group #(.WIDTH(1), .STICKY(1'b0)) u_line (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_i    (intx_in[i]),
                .clr_i    (1'b0),
                .en_set_i (intx_ens[i]),
                .en_clr_i (intx_enc[i]),
                .eoi_i    (intx_eoi[i]),
                .status_o (intx_stat[i]),
                .enable_o (intx_en[i]),
                .line_o   (intx_line[i])
            );
        end
    endgenerate

    assign msi_stat_flat = msi_stat;
    assign msi_en_flat   = msi_en;
    assign bus_rdata     = s_q.rdata;
endmodule

// File: rtl/irq_block_chk.sv
module irq_block_chk #(
    parameter int NUM_GROUPS = 8,
    parameter int GROUP_BITS = 4,
    parameter int NUM_INTX   = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             bus_valid,
    input logic                             bus_write,
    input logic [11:0]                      bus_addr,
    input logic [31:0]                      bus_wdata,
    input logic [NUM_GROUPS-1:0]            msi_line,
    input logic [NUM_INTX-1:0]              intx_line,
    input logic [NUM_GROUPS*GROUP_BITS-1:0] msi_stat_flat,
    input logic [NUM_GROUPS*GROUP_BITS-1:0] msi_en_flat,
    input logic [NUM_INTX-1:0]              intx_stat,
    input logic [NUM_INTX-1:0]              intx_en
);
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int BIT_W = (GROUP_BITS > 1) ? $clog2(GROUP_BITS) : 1;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (msi_line == '0 && intx_line == '0)); // R1

    AST_DOORBELL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 12'h054 && bus_wdata < 32'(NUM_GROUPS*GROUP_BITS))
        |=> msi_stat_flat[{$past(bus_wdata[GRP_W-1:0]), $past(bus_wdata[GRP_W +: BIT_W])}]); // R2

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_msi_chk
            AST_MSI_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(msi_line[g]) |->
                $past(|(msi_stat_flat[g*GROUP_BITS +: GROUP_BITS] & msi_en_flat[g*GROUP_BITS +: GROUP_BITS]))); // R5
            AST_MSI_FALL_EOI: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(msi_line[g]) |->
                $past(bus_valid && bus_write && bus_addr == 12'h050 && bus_wdata == 32'(g + 4))); // R6
        end
        for (genvar i = 0; i < NUM_INTX; i++) begin : g_intx_chk
            AST_INTX_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(intx_line[i]) |-> $past(intx_stat[i] && intx_en[i])); // R8
            AST_INTX_FALL_EOI: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(intx_line[i]) |->
                $past(bus_valid && bus_write && bus_addr == 12'h050 && bus_wdata == 32'(i))); // R9
        end
    endgenerate
endmodule

bind irq_block irq_block_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_BITS (GROUP_BITS),
    .NUM_INTX   (NUM_INTX)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .msi_line      (msi_line),
    .intx_line     (intx_line),
    .msi_stat_flat (msi_stat_flat),
    .msi_en_flat   (msi_en_flat),
    .intx_stat     (intx_stat),
    .intx_en       (intx_en)
);

// File: tb/irq_block_tb.sv
`timescale 1ns/1ps
module irq_block_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  intx_in = '0;
    logic [7:0]  msi_line;
    logic [3:0]  intx_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        logic [11:0] addr;
        logic [31:0] exp;
    } rd_item_t;
    rd_item_t exp_q[$];
    logic rd_seen = 1'b0;

    always #10 clk = ~clk;

    irq_block dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .intx_in(intx_in), .msi_line(msi_line), .intx_line(intx_line)
    );

    function automatic logic [11:0] msi_reg(int g, int sub);
        return 12'(32'h100 + 16 * g + 4 * sub);
    endfunction
    function automatic logic [11:0] intx_reg(int i, int sub);
        return 12'(32'h180 + 16 * i + 4 * sub);
    endfunction
    function automatic int vec_group(int v); return v % 8; endfunction
    function automatic int vec_bit(int v);   return v >> 3; endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(string req, logic [11:0] a, logic [31:0] exp);
        rd_item_t it;
        it.req = req; it.addr = a; it.exp = exp;
        @(negedge clk);
        exp_q.push_back(it);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // monitor: compare each read result one edge after its request
    always @(posedge clk) rd_seen <= bus_valid && !bus_write;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10: unexpected read data %h expected none", bus_rdata);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                chk($sformatf("%s read %h", it.req, it.addr), bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 msi_line", 32'(msi_line), 0);
        chk("R1 intx_line", 32'(intx_line), 0);
        chk("R1 rdata", bus_rdata, 0);
        bus_rd("R1", msi_reg(0, 1), 0);
        bus_rd("R1", msi_reg(3, 2), 0);
        bus_rd("R1", intx_reg(1, 1), 0);

        // R2 doorbell decode
        v = 13;
        bus_wr(12'h054, v);
        bus_rd("R2", msi_reg(vec_group(v), 1), 32'(1 << vec_bit(v)));
        // R7 not enabled -> no line
        chk("R7 msi_line", 32'(msi_line), 0);
        bus_wr(12'h054, 40);
        bus_wr(12'h054, 32);
        bus_rd("R2 out-of-range", msi_reg(0, 1), 0);
        bus_wr(12'h054, 31);
        bus_wr(12'h054, 24);
        bus_rd("R2", msi_reg(7, 1), 32'h8);
        bus_rd("R2", msi_reg(0, 1), 32'h8);
        bus_wr(msi_reg(7, 1), 32'h8);
        bus_wr(msi_reg(0, 1), 32'h8);

        // R4/R5 enable group 5 bit 1
        bus_wr(msi_reg(5, 2), 32'h2);
        @(negedge clk);
        chk("R5 msi_line", 32'(msi_line), 32'h20);
        bus_rd("R4", msi_reg(5, 2), 32'h2);
        bus_rd("R4", msi_reg(5, 3), 32'h2);

        // R3 write-one-to-clear
        bus_wr(msi_reg(5, 1), 32'h1);
        bus_rd("R3 zero bits kept", msi_reg(5, 1), 32'h2);
        bus_wr(msi_reg(5, 1), 32'h2);
        bus_rd("R3", msi_reg(5, 1), 32'h0);
        chk("R6 line held after clear", 32'(msi_line), 32'h20);

        // R6 EOI drops line, nothing pending -> stays low
        bus_wr(12'h050, 5 + 4);
        chk("R6 line drop", 32'(msi_line), 0);
        @(negedge clk);
        chk("R6 stays low", 32'(msi_line), 0);

        // R7 pending but disabled bit
        bus_wr(12'h054, 5);
        @(negedge clk);
        chk("R7 disabled bit", 32'(msi_line), 0);
        bus_wr(msi_reg(5, 2), 32'h1);
        @(negedge clk);
        chk("R5 enable late", 32'(msi_line), 32'h20);

        // R9 wrong EOI values
        bus_wr(12'h050, 8);
        @(negedge clk);
        chk("R9 other group eoi", 32'(msi_line), 32'h20);
        bus_wr(12'h050, 40);
        @(negedge clk);
        chk("R9 large eoi", 32'(msi_line), 32'h20);

        // R6 re-arm with pending still present
        bus_wr(12'h050, 9);
        chk("R6 drop on eoi", 32'(msi_line), 0);
        @(negedge clk);
        chk("R6 reassert", 32'(msi_line), 32'h20);

        // R4 enable clear
        bus_wr(msi_reg(5, 3), 32'h1);
        bus_rd("R4 clear", msi_reg(5, 2), 32'h2);

        // R8 INTx
        intx_in = 4'b0100;
        @(negedge clk);
        bus_rd("R8 status", intx_reg(2, 1), 32'h1);
        chk("R8 not enabled", 32'(intx_line), 0);
        bus_wr(intx_reg(2, 2), 32'h1);
        @(negedge clk);
        chk("R8 line", 32'(intx_line), 32'h4);
        bus_wr(12'h050, 3);
        @(negedge clk);
        chk("R9 other intx eoi", 32'(intx_line), 32'h4);
        bus_wr(12'h050, 2);
        chk("R8 eoi drop", 32'(intx_line), 0);
        @(negedge clk);
        chk("R8 reassert", 32'(intx_line), 32'h4);
        intx_in = 4'b0000;
        bus_wr(intx_reg(2, 1), 32'h1);
        bus_rd("R8 status follows input", intx_reg(2, 1), 32'h0);
        bus_wr(12'h050, 2);
        @(negedge clk);
        chk("R8 released", 32'(intx_line), 0);
        chk("R8 msi untouched", 32'(msi_line), 32'h20);
        bus_rd("R8 enable", intx_reg(2, 3), 32'h1);

        // R10 unmapped and misaligned
        bus_rd("R10 unmapped", 12'h300, 0);
        bus_rd("R10 sub0", 12'h150, 0);
        bus_rd("R10 misaligned", 12'h159, 0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R10: got %0d reads outstanding expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule